// File: doc/BRIEF.md
# Dual-Channel Saturating Wiper Counter

This block is the digital control for a two-channel adjustable resistor. Each channel holds a 7-bit tap position between code 0x00 and code 0x7F. After reset, both positions sit at midscale. A step strobe moves the positions one code at a time. The strobe acts only while the active-low chip select is asserted, and the direction input decides whether a step goes up or down. A position that has reached either end code stays there when further steps push past it.

A gang-mode input lets one strobe move both channels together. With gang mode off, a channel-pick input chooses which single channel moves. Each position is also decoded into a 128-line one-hot tap-select bus, which drives the switch ladder outside the block. The strobe is asynchronous to the system clock. It passes through a synchronizer, and the block acts on its falling edge. Chip select, direction, gang mode and channel pick are all sampled in the cycle in which that edge is detected.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, both positions read 0x40 and both tap buses have only bit 64 set, until the first accepted step.
- R2: A step is accepted only on a high-to-low transition of `step_in` while `sel_n` is low. A rising edge of `step_in` changes nothing. A falling edge while `sel_n` is high changes nothing.
- R3: An accepted step adds one to each selected position when `dir_up` is 1 and subtracts one when `dir_up` is 0.
- R4: A step up on a position already at 0x7F leaves it at 0x7F. The position never wraps to 0x00.
- R5: A step down on a position already at 0x00 leaves it at 0x00. The position never wraps to 0x7F.
- R6: When `gang_mode` is 1, an accepted step moves both channels and ignores `chan_pick`.
- R7: When `gang_mode` is 0, an accepted step moves only channel B if `chan_pick` is 1, and only channel A if `chan_pick` is 0. The other channel keeps its position.
- R8: Each tap bus is one-hot, with bit N set exactly when the matching position equals N. The bus changes in the same cycle as the position.
- R9: The position changes after the third rising clock edge that follows the fall of `step_in`. It is unchanged after the second.
- R10: `dir_up`, `sel_n`, `gang_mode` and `chan_pick` count only in the cycle the edge is detected. A change made after `step_in` falls, but before that cycle, takes effect.
- R11: Holding `step_in` high across reset release causes no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_in | input | 1 | Asynchronous step strobe, acts on its falling edge |
| sel_n | input | 1 | Active-low chip select gating steps |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| gang_mode | input | 1 | 1 = step both channels |
| chan_pick | input | 1 | With gang mode off: 1 = channel B, 0 = channel A |
| pos_a | output | 7 | Channel A position |
| pos_b | output | 7 | Channel B position |
| tap_a | output | 128 | Channel A one-hot tap select |
| tap_b | output | 128 | Channel B one-hot tap select |

## Verification
The assertions assume that `step_in` is clean: each level lasts long enough that the synchronizer sees every transition, so one detected edge matches one real fall. They also assume that the control inputs are settled in the cycle where an edge is detected. The stimulus holds `step_in` at each level for four clock cycles. It changes controls only on falling clock edges, and it changes them inside a strobe window only in the deliberate late-change case, where it still stays a full cycle clear of the detection edge. The assertions also take reset to be held for several cycles, so the synchronizer starts out low.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // Saturating single-code move within [0, top].
  function automatic int sat_step(int pos, logic up, int top);
    if (up) return (pos >= top) ? top : pos + 1;
    else    return (pos <= 0)   ? 0   : pos - 1;
  endfunction

  // Midscale code for a given position width.
  function automatic int mid_code(int width);
    return 1 << (width - 1);
  endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic fall_evt
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= strobe;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign fall_evt = last_q & ~chain_q[STAGES-1];

  // R2
  single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> !fall_evt);

endmodule

// File: rtl/step_router.sv
module step_router (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_evt,
  input  logic sel_n,
  input  logic gang_mode,
  input  logic chan_pick,
  output logic en_a,
  output logic en_b
);
  logic accept;

  assign accept = fall_evt & ~sel_n;
  assign en_a   = accept & (gang_mode | ~chan_pick);
  assign en_b   = accept & (gang_mode |  chan_pick);

  // R7
  single_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a && en_b) |-> gang_mode);

  // R2
  gated_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_a || en_b) |-> (fall_evt && !sel_n));

endmodule

// File: rtl/wiper_chan.sv
module wiper_chan #(
  parameter int POS_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               up,
  output logic [POS_W-1:0]   pos,
  output logic [(1<<POS_W)-1:0] tap
);
  import wiper_pkg::*;

  localparam int TAPS    = 1 << POS_W;
  localparam int TOP     = TAPS - 1;
  localparam logic [POS_W-1:0] MID = POS_W'(mid_code(POS_W));
  localparam logic [POS_W-1:0] MAXC = POS_W'(TOP);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  assign pos_d = POS_W'(sat_step(int'(pos_q), up, TOP));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  pos_q <= MID;
    else if (en) pos_q <= pos_d;

  assign pos = pos_q;

  generate
    genvar t;
    for (t = 0; t < TAPS; t++) begin : g_dec
      assign tap[t] = (pos_q == POS_W'(t));
    end
  endgenerate

  // R4 R5
  unit_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != $past(pos_q)) |->
      (({1'b0, pos_q} == {1'b0, $past(pos_q)} + 1'b1) ||
       ({1'b0, $past(pos_q)} == {1'b0, pos_q} + 1'b1)));

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pos_q));

  // R4
  top_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && up && pos_q == MAXC) |=> (pos_q == MAXC));

  // R5
  bottom_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !up && pos_q == '0) |=> (pos_q == '0));

  // R8
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap) == 1) && tap[pos_q]);

endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl #(
  parameter int POS_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step_in,
  input  logic                   sel_n,
  input  logic                   dir_up,
  input  logic                   gang_mode,
  input  logic                   chan_pick,
  output logic [POS_W-1:0]       pos_a,
  output logic [POS_W-1:0]       pos_b,
  output logic [(1<<POS_W)-1:0]  tap_a,
  output logic [(1<<POS_W)-1:0]  tap_b
);
  logic fall_evt;
  logic en_a;
  logic en_b;

  strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .strobe(step_in), .fall_evt(fall_evt));

  step_router u_route (
    .clk(clk), .rst_n(rst_n), .fall_evt(fall_evt), .sel_n(sel_n),
    .gang_mode(gang_mode), .chan_pick(chan_pick), .en_a(en_a), .en_b(en_b));

  wiper_chan #(.POS_W(POS_W)) u_chan_a (
    .clk(clk), .rst_n(rst_n), .en(en_a), .up(dir_up), .pos(pos_a), .tap(tap_a));

  wiper_chan #(.POS_W(POS_W)) u_chan_b (
    .clk(clk), .rst_n(rst_n), .en(en_b), .up(dir_up), .pos(pos_b), .tap(tap_b));

  // R6
  gang_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_evt && !sel_n && gang_mode) |-> (en_a && en_b));

  // R11
  no_ghost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> ($stable(pos_a) && $stable(pos_b)));

endmodule

// File: tb/sim_dual_wiper_ctrl.sv
module sim_dual_wiper_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0, sel_n = 1'b1, dir_up = 1'b1, gang_mode = 1'b0, chan_pick = 1'b0;
  logic [6:0]   pos_a, pos_b;
  logic [127:0] tap_a, tap_b;

  int n_chk = 0, n_fail = 0;
  int exp_a = 64, exp_b = 64;
  bit done = 0;

  always #2 clk = ~clk;

  dual_wiper_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .sel_n(sel_n), .dir_up(dir_up),
    .gang_mode(gang_mode), .chan_pick(chan_pick),
    .pos_a(pos_a), .pos_b(pos_b), .tap_a(tap_a), .tap_b(tap_b));

  function automatic int move(int p, bit up);
    if (up) return (p == 127) ? 127 : p + 1;
    return (p == 0) ? 0 : p - 1;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, pos_a, exp_a);
    chk(req, pos_b, exp_b);
    chk({req, " R8 tap_a"}, int'(tap_a == (128'd1 << exp_a)), 1);
    chk({req, " R8 tap_b"}, int'(tap_b == (128'd1 << exp_b)), 1);
  endtask

  task automatic pulse(bit cs_n, bit up, bit gang, bit pick);
    @(negedge clk);
    sel_n = cs_n; dir_up = up; gang_mode = gang; chan_pick = pick;
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
    if (!cs_n) begin
      if (gang || !pick) exp_a = move(exp_a, up);
      if (gang ||  pick) exp_b = move(exp_b, up);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog got=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    step_in = 1'b1;  // R11: strobe high across reset release
    repeat (4) @(negedge clk);
    chk_all("R1 in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk_all("R11 R1 after release");
    step_in = 1'b0; sel_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_all("R2 fall with sel_n high");

    // R9 latency and R2 rising edge no effect
    @(negedge clk); sel_n = 1'b0; dir_up = 1'b1; gang_mode = 1'b1;
    step_in = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R2 rising edge");
    step_in = 1'b0;
    @(negedge clk); @(negedge clk);
    chk_all("R9 after 2 edges");
    @(negedge clk);
    exp_a = 65; exp_b = 65;
    chk_all("R9 after 3 edges");

    // R10 late control change: down at fall, up before detection
    @(negedge clk); dir_up = 1'b0; step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    @(negedge clk); dir_up = 1'b1;
    repeat (4) @(negedge clk);
    exp_a = 66; exp_b = 66;
    chk_all("R10 late dir");

    // R7 single channel routing
    pulse(0, 1, 0, 0); chk_all("R7 A only");
    pulse(0, 0, 0, 1); chk_all("R7 B only");
    pulse(0, 0, 0, 1); chk_all("R3 down B");
    pulse(0, 1, 1, 1); chk_all("R6 gang ignores pick");
    pulse(1, 1, 1, 0); chk_all("R2 sel_n high");

    // R4 saturate top
    for (int i = 0; i < 70; i++) pulse(0, 1, 1, 0);
    chk_all("R4 at top");
    pulse(0, 1, 1, 0); chk_all("R4 extra up");
    chk(" R4 value", pos_a, 127);
    // R5 saturate bottom
    for (int i = 0; i < 132; i++) pulse(0, 0, 1, 0);
    chk_all("R5 at bottom");
    pulse(0, 0, 0, 1); chk_all("R5 extra down");
    chk("R5 value", pos_b, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      pulse(($urandom % 4) == 0, $urandom % 2, $urandom % 2, $urandom % 2);
      chk_all("R3 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule